// File: doc/BRIEF.md
# Cache Block Zeroing Sequencer

This block clears one data-cache block in memory when a block-zero request arrives. The request brings a base effective address, the configured data line size in bytes, a two-bit field taken from the mode register, and two instruction bits. The bits say whether the request is the tunable variant and, for that variant, whether the configured size is used as given. From these inputs the block picks an effective line size of 32, 64 or 128 bytes. It aligns the base address down to that size. It then issues one 32-bit zero write per word on a simple write port with valid and ready, in rising address order.

The block is busy from the cycle that follows acceptance until the last write is taken. A one-cycle done pulse follows. A load reservation held by the core is reported for clearing on the same cycle as done, but only if the reserved address lies inside the block that was just cleared. A request is taken only while the block is idle. A requester that arrives while the block is busy keeps its request asserted until the block is idle again.

Top module: `blkzero_seq`

## Requirements
- R1: With a configured size of 32, 64 or 128 on the fixed variant, the block issues exactly 8, 16 or 32 word writes per request.
- R2: Every write carries all-zero data.
- R3: Write addresses start at the aligned base and rise by 4 on each accepted write.
- R4: The first write address is the request address with its low bits cleared to a multiple of the effective line size.
- R5: When the size is resolved at run time (tunable variant with keep_size clear, or any unsupported configured size), a mode field value of binary 01 forces 32 bytes (8 writes). The other field values do not force the size.
- R6: When the configured size is supported and the request is either the fixed variant or the tunable variant with keep_size set, the configured size is used and the mode field has no effect.
- R7: An unsupported configured size resolves at run time to 32 writes if it is at least 128, to 16 writes if it is at least 64, and to 8 writes otherwise, subject to R5.
- R8: While wr_ready is low, wr_valid stays high and wr_addr holds its value.
- R9: busy and wr_valid are high from the cycle after acceptance until the last write handshake. done is high for exactly the one cycle after that handshake.
- R10: A request is accepted only while the block is idle. req_ready is low while busy, and a request that is withdrawn before the block goes idle causes no writes.
- R11: resv_clear is high together with done exactly when resv_valid was high and resv_addr lay inside the cleared block at the last write handshake.
- R12: After reset the block is idle: busy, wr_valid, done and resv_clear are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Block-zero request present |
| req_ready | output | 1 | High when a request would be accepted |
| req_addr | input | AW | Base effective address of the request |
| cfg_line_bytes | input | CFG_W | Configured data line size in bytes |
| mode_field | input | 2 | Override field from the mode register (01 forces 32 bytes) |
| req_tunable | input | 1 | Request is the tunable-size variant |
| req_keep_size | input | 1 | Tunable variant: use the configured size directly |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | AW | Write byte address |
| wr_data | output | DW | Write data (always zero) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| resv_valid | input | 1 | A load reservation is active |
| resv_addr | input | AW | Address of the reservation |
| resv_clear | output | 1 | Clear the reservation (valid with done) |

## Verification
The bound checker watches on every cycle that the write data is zero, that a stalled write holds its address, that consecutive accepted writes step by 4, that a sequence starts on a 32-byte boundary, and that done is a single pulse after a handshake with resv_clear only beside it. The checker cannot see how many writes a request deserves, which size wins between the configured value and the mode override, whether the base is aligned to 64 or 128 bytes, or whether a reservation lies in range. The bench's reference model and directed scenarios cover these, across both variants, unsupported sizes, random backpressure and a request raised while the block is busy.

// File: rtl/bz_pkg.sv
package bz_pkg;
    localparam int WORD_BYTES = 4;
    localparam int MAX_WORDS  = 32;
    localparam int IDX_W      = $clog2(MAX_WORDS);
    localparam int OFS_W      = IDX_W + $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        LS_32  = 2'd0,
        LS_64  = 2'd1,
        LS_128 = 2'd2
    } line_sel_e;

    // Index of the final word of a block of the given size.
    function automatic logic [IDX_W-1:0] last_idx(line_sel_e s);
        case (s)
            LS_32:   return IDX_W'(7);
            LS_64:   return IDX_W'(15);
            default: return IDX_W'(MAX_WORDS - 1);
        endcase
    endfunction

    // Byte-offset mask within a block of the given size.
    function automatic logic [OFS_W-1:0] ofs_mask(line_sel_e s);
        return {last_idx(s), 2'b11};
    endfunction
endpackage

// File: rtl/bz_size_sel.sv
module bz_size_sel
    import bz_pkg::*;
#(
    parameter int CFG_W = 9
) (
    input  logic [CFG_W-1:0] cfg_bytes,
    input  logic [1:0]       mode_field,
    input  logic             tunable,
    input  logic             keep_size,
    output line_sel_e        sel
);
    logic      is32, is64, is128, supported, forced, use_cfg;
    line_sel_e cfg_sel, run_sel;

    always_comb begin
        is32      = (cfg_bytes == CFG_W'(32));
        is64      = (cfg_bytes == CFG_W'(64));
        is128     = (cfg_bytes == CFG_W'(128));
        supported = is32 | is64 | is128;
        forced    = (mode_field == 2'b01);

        if (is128)     cfg_sel = LS_128;
        else if (is64) cfg_sel = LS_64;
        else           cfg_sel = LS_32;

        // Run-time path: threshold on configured size, then the override.
        if (forced)                         run_sel = LS_32;
        else if (cfg_bytes >= CFG_W'(128))  run_sel = LS_128;
        else if (cfg_bytes >= CFG_W'(64))   run_sel = LS_64;
        else                                run_sel = LS_32;

        use_cfg = supported && (!tunable || keep_size);
        sel     = use_cfg ? cfg_sel : run_sel;
    end
endmodule

// File: rtl/bz_align.sv
module bz_align
    import bz_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  line_sel_e     sel,
    output logic [AW-1:0] aligned
);
    localparam int HI_W = AW - OFS_W;

    always_comb begin
        aligned = addr & ~{{HI_W{1'b0}}, ofs_mask(sel)};
    end
endmodule

// File: rtl/blkzero_seq.sv
module blkzero_seq
    import bz_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CFG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic [CFG_W-1:0] cfg_line_bytes,
    input  logic [1:0]       mode_field,
    input  logic             req_tunable,
    input  logic             req_keep_size,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic             busy,
    output logic             done,
    input  logic             resv_valid,
    input  logic [AW-1:0]    resv_addr,
    output logic             resv_clear
);
    localparam int PAD_W = AW - OFS_W;

    typedef struct packed {
        logic             busy;
        line_sel_e        sel;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    base;
        logic             done;
        logic             clr;
    } seq_state_t;

    seq_state_t    s_d, s_q;
    line_sel_e     sel_w;
    logic [AW-1:0] req_base;
    logic [AW-1:0] resv_base;
    logic          resv_hit;
    logic          last_word;

    bz_size_sel #(.CFG_W(CFG_W)) u_size (
        .cfg_bytes  (cfg_line_bytes),
        .mode_field (mode_field),
        .tunable    (req_tunable),
        .keep_size  (req_keep_size),
        .sel        (sel_w)
    );

    bz_align #(.AW(AW)) u_req_align (
        .addr    (req_addr),
        .sel     (sel_w),
        .aligned (req_base)
    );

    bz_align #(.AW(AW)) u_resv_align (
        .addr    (resv_addr),
        .sel     (s_q.sel),
        .aligned (resv_base)
    );

    always_comb begin
        resv_hit  = resv_valid && (resv_base == s_q.base);
        last_word = (s_q.idx == last_idx(s_q.sel));

        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.clr  = 1'b0;
        if (s_q.busy) begin
            if (wr_ready) begin
                if (last_word) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.clr  = resv_hit;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
        end else if (req_valid) begin
            s_d.busy = 1'b1;
            s_d.sel  = sel_w;
            s_d.base = req_base;
            s_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready  = !s_q.busy;
    assign wr_valid   = s_q.busy;
    assign wr_addr    = s_q.base + {{PAD_W{1'b0}}, s_q.idx, 2'b00};
    assign wr_data    = '0;
    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign resv_clear = s_q.clr;
endmodule

// File: rtl/bz_checker.sv
module bz_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          busy,
    input logic          done,
    input logic          resv_clear
);
    AST_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data == '0);                                        // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || wr_addr == $past(wr_addr) + AW'(4))); // R3
    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> wr_addr[4:0] == 5'd0);                          // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));        // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R9
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_valid && wr_ready));                              // R9
    AST_START_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_ready));                     // R10
    AST_CLEAR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clear |-> done);                                               // R11
endmodule

bind blkzero_seq bz_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .busy       (busy),
    .done       (done),
    .resv_clear (resv_clear)
);

// File: tb/tb_blkzero_seq.sv
`timescale 1ns/1ps
module tb_blkzero_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [8:0]  cfg_line_bytes = 9'd32;
    logic [1:0]  mode_field = 2'b00;
    logic        req_tunable = 1'b0;
    logic        req_keep_size = 1'b0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        busy, done, resv_clear;
    logic        resv_valid = 1'b0;
    logic [31:0] resv_addr = '0;

    int checks = 0, failures = 0;
    bit rnd_ready = 1'b0;
    int wcnt = 0;
    logic [31:0] first_addr = '0;

    // behavioural reference state
    bit          m_busy = 0, m_done = 0, m_clr = 0;
    int          m_idx = 0, m_n = 0;
    logic [31:0] m_base = '0;

    always #2.5 clk = ~clk;

    blkzero_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .cfg_line_bytes(cfg_line_bytes), .mode_field(mode_field),
        .req_tunable(req_tunable), .req_keep_size(req_keep_size),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .resv_valid(resv_valid), .resv_addr(resv_addr),
        .resv_clear(resv_clear)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_words(int cfg, bit [1:0] mf, bit tun, bit keep);
        bit ok = (cfg == 32) || (cfg == 64) || (cfg == 128);
        if (ok && (!tun || keep)) return cfg / 4;
        if (mf == 2'b01) return 8;
        if (cfg >= 128) return 32;
        if (cfg >= 64)  return 16;
        return 8;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_clr = 0; m_idx = 0; m_n = 0; m_base = '0;
        end else begin
            bit nd, nc;
            nd = 0; nc = 0;
            if (m_busy) begin
                if (wr_ready) begin
                    if (m_idx == m_n - 1) begin
                        m_busy = 0;
                        nd = 1;
                        nc = resv_valid && (longint'(resv_addr) >= longint'(m_base))
                             && (longint'(resv_addr) < longint'(m_base) + m_n * 4);
                    end else m_idx++;
                end
            end else if (req_valid) begin
                m_n    = exp_words(int'(cfg_line_bytes), mode_field, req_tunable, req_keep_size);
                m_base = req_addr & ~(32'(m_n * 4 - 1));
                m_idx  = 0;
                m_busy = 1;
            end
            m_done = nd;
            m_clr  = nc;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === m_busy, "R9 busy", busy, m_busy);
            chk(wr_valid === m_busy, "R9 wr_valid", wr_valid, m_busy);
            chk(req_ready === !m_busy, "R10 req_ready", req_ready, !m_busy);
            if (m_busy) begin
                chk(wr_addr === m_base + 32'(m_idx * 4), "R3 wr_addr", wr_addr, m_base + 32'(m_idx * 4));
                chk(wr_data === 32'd0, "R2 wr_data", wr_data, 0);
            end
            chk(done === m_done, "R9 done", done, m_done);
            chk(resv_clear === m_clr, "R11 resv_clear", resv_clear, m_clr);
            if (wr_valid && wr_ready) begin
                if (wcnt == 0) first_addr = wr_addr;
                wcnt++;
            end
        end
    end

    initial forever begin
        @(posedge clk);
        #1;
        wr_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
    end

    task automatic run_req(input logic [31:0] a, input int cfg, input bit [1:0] mf,
                           input bit tun, input bit keep, input int en,
                           input logic [31:0] eb, input string tag);
        @(negedge clk); #1;
        req_addr = a; cfg_line_bytes = 9'(cfg); mode_field = mf;
        req_tunable = tun; req_keep_size = keep; req_valid = 1'b1; wcnt = 0;
        @(negedge clk);
        while (!busy) @(negedge clk);
        #1 req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(wcnt == en, tag, wcnt, en);
        chk(first_addr == eb, "R4 base", first_addr, eb);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && wr_valid == 0 && done == 0 && resv_clear == 0, "R12 idle outputs", busy, 0);
        chk(req_ready == 1, "R12 req_ready", req_ready, 1);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_req(32'h1000_0013, 32,  2'b00, 0, 0, 8,  32'h1000_0000, "R1 fixed 32");
        run_req(32'h2000_0047, 64,  2'b00, 0, 0, 16, 32'h2000_0040, "R1 fixed 64");
        run_req(32'h3000_00FF, 128, 2'b00, 0, 0, 32, 32'h3000_0080, "R1 fixed 128");
        run_req(32'h3100_0004, 128, 2'b01, 0, 0, 32, 32'h3100_0000, "R6 fixed ignores field");
        run_req(32'h3200_0010, 128, 2'b01, 1, 1, 32, 32'h3200_0000, "R6 tunable keep ignores field");
        run_req(32'h4000_0065, 128, 2'b01, 1, 0, 8,  32'h4000_0060, "R5 field forces 32");
        run_req(32'h4100_0078, 64,  2'b11, 1, 0, 16, 32'h4100_0040, "R5 field 11 no force");
        run_req(32'h4200_00F0, 128, 2'b00, 1, 0, 32, 32'h4200_0080, "R5 run-time no force");
        run_req(32'h5000_0050, 96,  2'b00, 0, 0, 16, 32'h5000_0040, "R7 size 96");
        run_req(32'h5100_0090, 256, 2'b00, 0, 0, 32, 32'h5100_0080, "R7 size 256");
        run_req(32'h5200_0024, 16,  2'b00, 1, 1, 8,  32'h5200_0020, "R7 size 16");
        run_req(32'h5300_00C4, 200, 2'b01, 0, 0, 8,  32'h5300_00C0, "R7 size 200 forced");

        rnd_ready = 1'b1;
        run_req(32'h6000_0000, 128, 2'b00, 0, 0, 32, 32'h6000_0000, "R8 backpressure 128");
        run_req(32'h6100_0044, 64,  2'b10, 1, 0, 16, 32'h6100_0040, "R8 backpressure 64");

        // reservation inside, then outside, the cleared block
        resv_valid = 1'b1; resv_addr = 32'h7000_0038;
        run_req(32'h7000_0020, 64, 2'b00, 0, 0, 16, 32'h7000_0000, "R11 words");
        chk(resv_clear == 1, "R11 inside", resv_clear, 1);
        resv_addr = 32'h7000_0040;
        run_req(32'h7000_0020, 64, 2'b00, 0, 0, 16, 32'h7000_0000, "R11 words");
        chk(resv_clear == 0, "R11 outside", resv_clear, 0);
        resv_valid = 1'b0; resv_addr = 32'h7000_0010;
        run_req(32'h7000_0020, 64, 2'b00, 0, 0, 16, 32'h7000_0000, "R11 words");
        chk(resv_clear == 0, "R11 not valid", resv_clear, 0);

        // second request raised while busy, withdrawn before idle
        @(negedge clk); #1;
        req_addr = 32'h8000_0000; cfg_line_bytes = 9'd128; mode_field = 2'b00;
        req_tunable = 0; req_keep_size = 0; req_valid = 1'b1; wcnt = 0;
        @(negedge clk);
        while (!busy) @(negedge clk);
        #1 req_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1 req_valid = 1'b1; req_addr = 32'h9000_0000; cfg_line_bytes = 9'd32;
        repeat (4) @(negedge clk);
        chk(busy == 1 && req_ready == 0, "R10 still busy", busy, 1);
        #1 req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(wcnt == 32, "R10 no extra writes", wcnt, 32);
        chk(first_addr == 32'h8000_0000, "R10 first block", first_addr, 32'h8000_0000);
        @(negedge clk);
        chk(busy == 0, "R10 withdrawn not taken", busy, 0);
        rnd_ready = 1'b0;

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule